// File: doc/BRIEF.md
# Window Watchdog Reset Generator

This block asks for a system reset when software stops servicing it correctly. A prescaler divides the watchdog clock into ticks, and each tick lowers a down-counter. The counter starts from a programmable reload value. Software must pulse a refresh strobe before the counter runs out. When that happens, the counter reloads and the prescaler restarts from zero. Without a refresh, the time to reset is the reload value multiplied by the prescale ratio, counted in watchdog clock cycles.

An optional window makes early refreshes illegal as well. While the window is enabled, a refresh is accepted only when the counter value is at or below the programmed window value. A refresh seen while the counter is still above the window raises the reset request at once, just as an expired countdown does. The block runs entirely on its own clock input, so it can be fed from an oscillator that does not depend on the main system clock.

The controller is a three-state machine:
- **LOAD** copies the reload value into the counter and clears the prescaler.
- **RUN** counts down and judges refreshes.
- **FIRE** drives the reset request.

Its transitions are:
- LOAD→RUN, taken always.
- RUN→RUN, taken on a tick or an accepted refresh.
- RUN→FIRE, taken on an early refresh or on expiry.
- FIRE→FIRE, taken while the hold count runs.
- FIRE→LOAD, taken after the last hold cycle.

Top module: `wdg_window_reset`

## Requirements
- R1: The prescaler issues one tick every N clock cycles, where N is `presc_i`; a value of 0 acts as 1.
- R2: With no refresh, `rst_req_o` rises in the cycle reached R×N clock edges after the load edge, where R is `reload_i`. A reload of 0 acts as 1.
- R3: An accepted refresh reloads the counter from `reload_i` and clears the prescaler at the edge that samples it, so the next timeout is R×N edges after that edge.
- R4: With `win_en_i` low, a refresh is accepted at any point of the countdown, including the first cycle after a load.
- R5: With `win_en_i` high, a refresh sampled while the counter is above `window_i` raises `rst_req_o` after that same edge. The counter sits above the window up to and including load edge + (R−W)×N, where W is `window_i`.
- R6: With `win_en_i` high, a refresh sampled while the counter is at or below `window_i` is accepted. The first such edge is load edge + (R−W)×N + 1.
- R7: A refresh sampled on the very edge at which the countdown would expire is accepted and no reset is requested.
- R8: `rst_req_o` stays high for exactly 4 clock cycles per request.
- R9: A refresh while `rst_req_o` is high has no effect on the pulse length or on the next timeout.
- R10: After the pulse, one LOAD cycle reloads the counter. The next unserviced request therefore rises 4 + 1 + R×N cycles after the previous rise.
- R11: While `rst_n` is low, `rst_req_o` is low. The first clock edge after release is a load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock, may come from an independent oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_i | input | 1 | One-cycle refresh strobe from software |
| presc_i | input | PRESC_W | Prescale ratio N (0 treated as 1) |
| reload_i | input | CNT_W | Countdown start value R |
| window_i | input | CNT_W | Window threshold W; refresh legal when counter ≤ W |
| win_en_i | input | 1 | Enables the early-refresh check |
| rst_req_o | output | 1 | Reset request, held 4 cycles |

## Verification
The hardest cases to reach from the ports are the two single-cycle boundaries. One is the last edge on which the counter still sits above the window. The other is the edge on which the countdown expires exactly as a refresh arrives. Neither boundary is visible on an output. The bench therefore counts clock edges from a known load edge and derives each boundary from R, W and N. It then places the refresh strobe on the computed edge or one edge before it. For every case it queues the absolute cycle at which the reset request must rise, or must not rise.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdg_state_e;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               clr_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);
    logic [PRESC_W-1:0] pcnt_q;
    logic [PRESC_W-1:0] ratio;
    logic               hit;

    // a zero ratio behaves as divide-by-one
    assign ratio  = (presc_i == '0) ? PRESC_W'(1) : presc_i;
    assign hit    = (pcnt_q >= ratio - PRESC_W'(1));
    assign tick_o = run_i && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run_i || clr_i || hit) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PRESC_W'(1);
        end
    end

    // ticks are spaced by the ratio: never back to back above divide-by-one
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !clr_i && presc_i > PRESC_W'(1)) |=> !tick_o);
endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(reload_i)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_o));
endmodule

// File: rtl/wdg_ctrl_fsm.sv
module wdg_ctrl_fsm
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_i,
    input  logic             win_en_i,
    input  logic [CNT_W-1:0] window_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tick_i,
    output logic             load_o,
    output logic             run_o,
    output logic             rst_req_o
);
    localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    wdg_state_e        st_q, st_d;
    logic [HOLD_W-1:0] hold_q;
    logic              too_early;
    logic              refresh_ok;
    logic              expire;

    assign too_early  = win_en_i && (cnt_i > window_i);
    assign refresh_ok = (st_q == ST_RUN) && refresh_i && !too_early;
    assign expire     = tick_i && (cnt_i <= CNT_W'(1));

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOAD: st_d = ST_RUN;
            ST_RUN: begin
                if (refresh_i && too_early) begin
                    st_d = ST_FIRE;
                end else if (refresh_i) begin
                    st_d = ST_RUN;
                end else if (expire) begin
                    st_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                if (hold_q == HOLD_W'(HOLD_CYC - 1)) begin
                    st_d = ST_LOAD;
                end
            end
            default: st_d = ST_LOAD;
        endcase
    end

    // state register and hold counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_LOAD;
            hold_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_FIRE && st_d == ST_FIRE) begin
                hold_q <= hold_q + HOLD_W'(1);
            end else begin
                hold_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        load_o    = 1'b0;
        run_o     = 1'b0;
        rst_req_o = 1'b0;
        unique case (st_q)
            ST_LOAD: load_o = 1'b1;
            ST_RUN: begin
                run_o  = 1'b1;
                load_o = refresh_ok;
            end
            ST_FIRE: rst_req_o = 1'b1;
            default: load_o = 1'b1;
        endcase
    end

    assert_early_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && refresh_i && win_en_i && cnt_i > window_i) |=> rst_req_o);

    assert_open_refresh_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && refresh_i && (!win_en_i || cnt_i <= window_i)) |=> !rst_req_o);

    assert_pulse_not_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_req_o) && HOLD_CYC > 1) |=> rst_req_o);

    assert_reload_after_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> load_o);
endmodule

// File: rtl/wdg_window_reset.sv
module wdg_window_reset #(
    parameter int PRESC_W  = 8,
    parameter int CNT_W    = 8,
    parameter int HOLD_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               refresh_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic [CNT_W-1:0]   reload_i,
    input  logic [CNT_W-1:0]   window_i,
    input  logic               win_en_i,
    output logic               rst_req_o
);
    logic             tick;
    logic             load;
    logic             run;
    logic [CNT_W-1:0] cnt;

    wdg_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clr_i   (load),
        .presc_i (presc_i),
        .tick_o  (tick)
    );

    wdg_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .reload_i (reload_i),
        .tick_i   (tick),
        .cnt_o    (cnt)
    );

    wdg_ctrl_fsm #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .refresh_i (refresh_i),
        .win_en_i  (win_en_i),
        .window_i  (window_i),
        .cnt_i     (cnt),
        .tick_i    (tick),
        .load_o    (load),
        .run_o     (run),
        .rst_req_o (rst_req_o)
    );

    // the request never comes straight out of the load cycle
    assert_no_req_at_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !rst_req_o);
endmodule

// File: tb/wdg_window_reset_bench.sv
`timescale 1ns/1ps
module wdg_window_reset_bench;
    localparam int PW = 8;
    localparam int CW = 8;
    localparam int HOLD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh = 1'b0;
    logic [PW-1:0] presc = 8'd3;
    logic [CW-1:0] reload = 8'd10;
    logic [CW-1:0] window = 8'd0;
    logic          win_en = 1'b0;
    logic          rst_req;

    int cyc = 0;
    int checks = 0;
    int bad = 0;
    int rises_seen = 0;
    int exp_q[$];
    string tag_q[$];

    wdg_window_reset #(.PRESC_W(PW), .CNT_W(CW), .HOLD_CYC(HOLD)) u_wdg_window_reset (
        .clk       (clk),
        .rst_n     (rst_n),
        .refresh_i (refresh),
        .presc_i   (presc),
        .reload_i  (reload),
        .window_i  (window),
        .win_en_i  (win_en),
        .rst_req_o (rst_req)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_rise(input int at, input string tag);
        exp_q.push_back(at);
        tag_q.push_back(tag);
    endtask

    task automatic refresh_at(input int target);
        while (cyc < target - 1) @(negedge clk);
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    task automatic wait_rise(input int k);
        wait (rises_seen == k);
    endtask

    // monitor: pops the expected rise cycle and measures the pulse width
    logic prev = 1'b0;
    int   rise_at = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rst_req && !prev) begin
                rise_at = cyc;
                checks++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL unexpected request: actual rise=%0d expected none", cyc);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e != cyc) begin
                        bad++;
                        $display("FAIL %s: actual rise=%0d expected=%0d", t, cyc, e);
                    end
                end
                rises_seen++;
            end
            if (!rst_req && prev) begin
                checks++;
                if (cyc - rise_at != HOLD) begin
                    bad++;
                    $display("FAIL R8 pulse width: actual=%0d expected=%0d", cyc - rise_at, HOLD);
                end
            end
            prev = rst_req;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int ld, er, f;
        repeat (5) @(negedge clk);
        checks++;
        if (rst_req !== 1'b0) begin
            bad++;
            $display("FAIL R11 in reset: actual=%b expected=0", rst_req);
        end
        rst_n = 1'b1;
        @(negedge clk);
        ld = cyc;
        checks++;
        if (rst_req !== 1'b0) begin
            bad++;
            $display("FAIL R11 after release: actual=%b expected=0", rst_req);
        end

        // R2 / R11: timeout from the first load edge, N=3 R=10
        expect_rise(ld + 30, "R2 first timeout");
        wait_rise(1);
        f = ld + 30;

        // R9 / R10: refresh inside the pulse is ignored, auto restart
        refresh_at(f + 2);
        expect_rise(f + HOLD + 1 + 30, "R10 restart");
        wait_rise(2);
        f = f + HOLD + 1 + 30;

        // R3 / R4: window off, refresh right after load accepted; N=2 R=6
        presc = 8'd2;
        reload = 8'd6;
        ld = f + HOLD + 1;
        refresh_at(ld + 1);
        er = ld + 1 + 7;
        refresh_at(er);
        expect_rise(er + 12, "R3 reload on refresh");
        wait_rise(3);
        f = er + 12;

        // R6 / R5: window W=4, N=2, R=10: first open edge is load+13
        presc = 8'd2;
        reload = 8'd10;
        window = 8'd4;
        win_en = 1'b1;
        ld = f + HOLD + 1;
        refresh_at(ld + 13);
        er = ld + 13;
        expect_rise(er + 12, "R5 early refresh");
        refresh_at(er + 12);
        wait_rise(4);
        f = er + 12;

        // R7: refresh on the expiry edge is accepted
        ld = f + HOLD + 1;
        refresh_at(ld + 20);
        er = ld + 20;
        expect_rise(er + 20, "R7 refresh at expiry");
        wait_rise(5);
        f = er + 20;

        // R1: ratio 0 behaves as 1
        presc = 8'd0;
        reload = 8'd5;
        win_en = 1'b0;
        expect_rise(f + HOLD + 1 + 5, "R1 ratio zero");
        wait_rise(6);
        f = f + HOLD + 1 + 5;

        // R1: ratio 1
        presc = 8'd1;
        expect_rise(f + HOLD + 1 + 5, "R1 ratio one");
        wait_rise(7);
        f = f + HOLD + 1 + 5;

        // R2: reload 0 behaves as 1
        presc = 8'd3;
        reload = 8'd0;
        expect_rise(f + HOLD + 1 + 3, "R2 reload zero");
        wait_rise(8);

        repeat (HOLD + 2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL pending requests: actual=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule